// File: doc/BRIEF.md
# ATM Transmit Cell Processor with Idle Fill

This block sits between a cell source and a transmission framer. Cells arrive over a synchronous byte-wide write port, one 53-byte cell per burst. The first byte of each burst is marked with a start flag. The cells are held in a small cell buffer whose usable size can be set from one to four cells.

On its output side the block produces an unbroken stream of cells, one byte per clock. Whenever the buffer lacks a complete cell, or the transmit-off input is raised at a cell boundary, it emits an idle cell instead. The header error check byte of every outgoing cell is computed on the fly. The generic flow control nibble can be overwritten after the buffer from a serial input, so that nibble does not wait behind buffered cells. The 48 payload bytes can optionally pass through a self-synchronising scrambler.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While reset is held, `tx_soc` is 0, `tx_idle` is 1, `wr_room` is 1 and `wr_ovf` is 0.
- R2: After reset the output carries one byte per clock as back-to-back 53-byte cells. `tx_soc` is high on byte 0 of every cell and on no other byte.
- R3: The effective buffer size is `cfg_depth` for values 1 to 4, 1 for value 0, and 4 for values 5 to 7. `wr_room` is high exactly when the number of complete buffered cells plus any cell being written is below that size.
- R4: A byte written with `wr_soc` high while `wr_room` is low starts no cell. `wr_ovf` is high in the following cycle only. The dropped cell never appears on the output, and the bytes that follow it without `wr_soc` are ignored.
- R5: A cell whose 53rd byte has not yet been written is never sent. With no complete cell buffered, an idle cell is sent. An idle cell has header bytes 00 00 00 01, payload bytes 0x6A before scrambling, and `tx_idle` high on all its bytes.
- R6: `xoff` is sampled only when byte 0 of a cell is chosen. If it is high, that cell is idle. A cell whose transmission has started is always completed.
- R7: Buffered cells leave in write order. Header bytes 0 to 3 and payload bytes 5 to 52 keep their written values, apart from R8 and R10. The written byte 4 is discarded.
- R8: With `cfg_gfc_en` high, bits 7:4 of byte 0 of every non-idle cell carry the last four values sampled on `gfc_sdata`, one per clock, with the oldest in bit 7. Idle cells are never modified.
- R9: Byte 4 of every cell equals the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, MSB first) of the transmitted bytes 0 to 3, XORed with 0x55. For idle cells this gives 0x52.
- R10: With `cfg_scr_en` high, payload bytes 5 to 52 of all cells are scrambled MSB first by a x^43+1 self-synchronising scrambler. Each output bit is the input bit XOR the bit sent 43 bits earlier. The scrambler state is zero after reset and advances only over payload bytes. With `cfg_scr_en` low, payload passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth | input | 3 | Usable buffer size in cells |
| cfg_scr_en | input | 1 | Payload scrambler enable |
| cfg_gfc_en | input | 1 | Late flow-control nibble insertion enable |
| xoff | input | 1 | Transmit off, idle cells only from next boundary |
| gfc_sdata | input | 1 | Serial flow-control bits |
| wr_en | input | 1 | Write byte valid |
| wr_soc | input | 1 | Marks byte 0 of a written cell |
| wr_data | input | 8 | Written cell byte |
| wr_room | output | 1 | Space exists for a full cell |
| wr_ovf | output | 1 | Cell rejected for lack of space |
| tx_data | output | 8 | Outgoing cell byte |
| tx_soc | output | 1 | Byte 0 of an outgoing cell |
| tx_idle | output | 1 | Outgoing byte belongs to an idle cell |

## Verification
A wrong fill count shows at once as a wrong `wr_room` level before the next written cell, or as a missing or extra cell at the next output boundary. A corrupted byte index breaks the 53-byte spacing of `tx_soc` within one cell time. A wrong CRC or scrambler state corrupts byte 4 or the payload of the very next cell. A stale transmit-off decision turns a whole cell from data to idle, or the reverse. The bench therefore rebuilds every outgoing cell from its own model and compares all 53 bytes, and it counts data cells per configuration.

// File: rtl/atm_tx_pkg.sv
`timescale 1ns/1ps
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HCS_POS    = 4;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int GFC_W      = 4;
  localparam int SCR_TAPS   = 43;

  localparam logic [7:0] IDLE_FILL = 8'h6A;
  localparam logic [7:0] HCS_COSET = 8'h55;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  // one byte of CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] data);
    logic [7:0] c;
    c = crc_in ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

  // idle header: 00 00 00 01
  function automatic logic [7:0] idle_hdr_byte(input logic [IDX_W-1:0] pos);
    return (pos == IDX_W'(HDR_BYTES - 1)) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/atm_tx_cell_fifo.sv
`timescale 1ns/1ps
module atm_tx_cell_fifo
  import atm_tx_pkg::*;
#(
  parameter int NCELLS = 4,
  localparam int DEPTH_W   = $clog2(NCELLS + 1),
  localparam int SLOT_W    = (NCELLS > 1) ? $clog2(NCELLS) : 1,
  localparam int MEM_WORDS = NCELLS * CELL_BYTES,
  localparam int ADDR_W    = $clog2(MEM_WORDS)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               wr_en,
  input  logic               wr_soc,
  input  logic [7:0]         wr_data,
  output logic               wr_room,
  output logic               wr_ovf,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic               rd_release,
  output logic [7:0]         rd_data,
  output logic               cell_ready
);
  logic [7:0]         mem_q [MEM_WORDS];
  logic [SLOT_W-1:0]  wslot_q, wslot_d, rslot_q, rslot_d;
  logic [IDX_W-1:0]   widx_q, widx_d;
  logic               wact_q, wact_d;
  logic [DEPTH_W-1:0] full_q, full_d;
  logic               ovf_q, ovf_d;
  logic [DEPTH_W-1:0] depth_eff, used;
  logic               start_ok, reject, we, last;
  logic [IDX_W-1:0]   w_pos;
  logic [ADDR_W-1:0]  w_addr, r_addr;

  always_comb begin
    if (cfg_depth == '0)                        depth_eff = DEPTH_W'(1);
    else if (cfg_depth > DEPTH_W'(NCELLS))      depth_eff = DEPTH_W'(NCELLS);
    else                                        depth_eff = cfg_depth;
    used     = full_q + DEPTH_W'(wact_q);
    wr_room  = used < depth_eff;
    // a start flag inside an active cell restarts that cell in place
    start_ok = wr_en & wr_soc & (wact_q | wr_room);
    reject   = wr_en & wr_soc & ~wact_q & ~wr_room;
    we       = start_ok | (wr_en & ~wr_soc & wact_q);
    last     = wr_en & ~wr_soc & wact_q & (widx_q == IDX_W'(CELL_BYTES - 1));
    w_pos    = wr_soc ? '0 : widx_q;
    w_addr   = ADDR_W'(wslot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(w_pos);
    r_addr   = ADDR_W'(rslot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(rd_idx);

    wact_d  = start_ok ? 1'b1 : (last ? 1'b0 : wact_q);
    widx_d  = start_ok ? IDX_W'(1) : (we ? widx_q + 1'b1 : widx_q);
    wslot_d = wslot_q;
    if (last) wslot_d = (wslot_q == SLOT_W'(NCELLS - 1)) ? '0 : wslot_q + 1'b1;
    rslot_d = rslot_q;
    if (rd_release) rslot_d = (rslot_q == SLOT_W'(NCELLS - 1)) ? '0 : rslot_q + 1'b1;
    full_d  = full_q + DEPTH_W'(last) - DEPTH_W'(rd_release);
    ovf_d   = reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      widx_q  <= '0;
      wact_q  <= 1'b0;
      full_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wslot_q <= wslot_d;
      rslot_q <= rslot_d;
      widx_q  <= widx_d;
      wact_q  <= wact_d;
      full_q  <= full_d;
      ovf_q   <= ovf_d;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (we) mem_q[w_addr] <= wr_data;
  end

  assign rd_data    = mem_q[r_addr];
  assign cell_ready = (full_q != '0);
  assign wr_ovf     = ovf_q;

  // R3: buffered plus in-progress cells never exceed the physical slots
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, full_q} + {{DEPTH_W{1'b0}}, wact_q}) <= (DEPTH_W + 1)'(NCELLS));
  // R7: a cell is only released when a complete one is held
  a_r7_release_has_cell: assert property (@(posedge clk) disable iff (!rst_n)
    rd_release |-> cell_ready);
  // R4: an overflow flag always follows a start byte
  a_r4_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |-> $past(wr_en && wr_soc));
endmodule

// File: rtl/atm_tx_payload_scr.sv
`timescale 1ns/1ps
module atm_tx_payload_scr
  import atm_tx_pkg::*;
#(
  parameter int TAPS = SCR_TAPS
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [TAPS-1:0] st_q, st_d;

  always_comb begin
    logic [7:0] o;
    st_d = st_q;
    o    = '0;
    for (int i = 7; i >= 0; i--) begin
      o[i] = din[i] ^ st_d[TAPS-1];
      st_d = {st_d[TAPS-2:0], o[i]};
    end
    dout = o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (advance) st_q <= st_d;
  end
endmodule

// File: rtl/atm_tx_cell_seq.sv
`timescale 1ns/1ps
module atm_tx_cell_seq
  import atm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xoff,
  input  logic             cfg_scr_en,
  input  logic             cfg_gfc_en,
  input  logic             gfc_sdata,
  input  logic             cell_ready,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_release,
  output logic [7:0]       tx_data,
  output logic             tx_soc,
  output logic             tx_idle
);
  logic [IDX_W-1:0] idx_q, idx_d, opos_q;
  logic             asg_q, send_now;
  logic [7:0]       crc_q, crc_d;
  logic [GFC_W-1:0] gfc_q;
  logic [7:0]       odata_q, byte_d, hdr_b, pay_raw, pay_scr;
  logic             osoc_q, oidle_q;
  logic             is_hdr, is_hcs, scr_adv;

  always_comb begin
    is_hdr   = idx_q < IDX_W'(HDR_BYTES);
    is_hcs   = idx_q == IDX_W'(HCS_POS);
    // transmit-off and buffer state only matter at byte 0
    send_now = (idx_q == '0) ? (cell_ready & ~xoff) : asg_q;
    hdr_b    = send_now ? rd_data : idle_hdr_byte(idx_q);
    if ((idx_q == '0) && send_now && cfg_gfc_en) hdr_b = {gfc_q, rd_data[3:0]};
    pay_raw  = send_now ? rd_data : IDLE_FILL;
    scr_adv  = cfg_scr_en & ~is_hdr & ~is_hcs;
    if (is_hdr)       byte_d = hdr_b;
    else if (is_hcs)  byte_d = crc_q ^ HCS_COSET;
    else              byte_d = cfg_scr_en ? pay_scr : pay_raw;
    crc_d = crc_q;
    if (is_hdr) crc_d = crc8_step((idx_q == '0) ? 8'h00 : crc_q, hdr_b);
    idx_d = (idx_q == IDX_W'(CELL_BYTES - 1)) ? '0 : idx_q + 1'b1;
  end

  assign rd_idx     = idx_q;
  assign rd_release = send_now & (idx_q == IDX_W'(CELL_BYTES - 1));

  atm_tx_payload_scr u_scr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (scr_adv),
    .din     (pay_raw),
    .dout    (pay_scr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      opos_q  <= '0;
      asg_q   <= 1'b0;
      crc_q   <= '0;
      gfc_q   <= '0;
      odata_q <= '0;
      osoc_q  <= 1'b0;
      oidle_q <= 1'b1;
    end else begin
      idx_q   <= idx_d;
      opos_q  <= idx_q;
      asg_q   <= send_now;
      crc_q   <= crc_d;
      gfc_q   <= {gfc_q[GFC_W-2:0], gfc_sdata};
      odata_q <= byte_d;
      osoc_q  <= (idx_q == '0);
      oidle_q <= ~send_now;
    end
  end

  assign tx_data = odata_q;
  assign tx_soc  = osoc_q;
  assign tx_idle = oidle_q;

  // R6: transmit-off at a boundary yields an idle cell
  a_r6_xoff_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0 && xoff) |=> tx_idle);
  // R5: no complete cell at a boundary yields an idle cell
  a_r5_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0 && !cell_ready) |=> tx_idle);
  // R6: cell kind never changes inside a cell
  a_r6_cell_atomic: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_soc |-> (tx_idle == $past(tx_idle)));
  // R2: start flags are never adjacent
  a_r2_soc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |=> !tx_soc);
  // R9: idle check byte is fixed
  a_r9_idle_hcs: assert property (@(posedge clk) disable iff (!rst_n)
    (opos_q == IDX_W'(HCS_POS) && tx_idle) |-> (tx_data == 8'h52));
endmodule

// File: rtl/atm_tx_cell_proc.sv
`timescale 1ns/1ps
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int NCELLS = 4,
  localparam int DEPTH_W = $clog2(NCELLS + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               cfg_scr_en,
  input  logic               cfg_gfc_en,
  input  logic               xoff,
  input  logic               gfc_sdata,
  input  logic               wr_en,
  input  logic               wr_soc,
  input  logic [7:0]         wr_data,
  output logic               wr_room,
  output logic               wr_ovf,
  output logic [7:0]         tx_data,
  output logic               tx_soc,
  output logic               tx_idle
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_release, cell_ready;
  logic [7:0]       rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  atm_tx_cell_fifo #(.NCELLS(NCELLS)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_depth  (cfg_depth),
    .wr_en      (wr_en),
    .wr_soc     (wr_soc),
    .wr_data    (wr_data),
    .wr_room    (wr_room),
    .wr_ovf     (wr_ovf),
    .rd_idx     (rd_idx),
    .rd_release (rd_release),
    .rd_data    (rd_data),
    .cell_ready (cell_ready)
  );

  atm_tx_cell_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .xoff       (xoff),
    .cfg_scr_en (cfg_scr_en),
    .cfg_gfc_en (cfg_gfc_en),
    .gfc_sdata  (gfc_sdata),
    .cell_ready (cell_ready),
    .rd_data    (rd_data),
    .rd_idx     (rd_idx),
    .rd_release (rd_release),
    .tx_data    (tx_data),
    .tx_soc     (tx_soc),
    .tx_idle    (tx_idle)
  );
endmodule

// File: tb/atm_tx_cell_proc_tb_top.sv
`timescale 1ns/1ps
module atm_tx_cell_proc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_depth = 3'd4;
  logic       cfg_scr_en = 1'b0, cfg_gfc_en = 1'b0, xoff = 1'b0, gfc_sdata = 1'b0;
  logic       wr_en = 1'b0, wr_soc = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_room, wr_ovf, tx_soc, tx_idle;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  atm_tx_cell_proc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_scr_en(cfg_scr_en),
    .cfg_gfc_en(cfg_gfc_en), .xoff(xoff), .gfc_sdata(gfc_sdata),
    .wr_en(wr_en), .wr_soc(wr_soc), .wr_data(wr_data),
    .wr_room(wr_room), .wr_ovf(wr_ovf),
    .tx_data(tx_data), .tx_soc(tx_soc), .tx_idle(tx_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected cell queue
  logic [7:0] q_mem [0:31][0:52];
  int q_head = 0, q_tail = 0;
  int data_cells = 0;
  bit must_idle = 0;
  bit saw_data = 0;
  bit tb_scr = 0;
  logic [42:0] sst;

  function automatic logic [7:0] cell_byte(input logic [7:0] h0, input logic [7:0] seed, input int i);
    case (i)
      0: return h0;
      1: return seed;
      2: return 8'h3C ^ seed;
      3: return {seed[3:0], 4'h4};
      4: return 8'hEE;
      default: return seed + 8'(i * 3);
    endcase
  endfunction

  task automatic push_cell(input logic [7:0] h0, input logic [7:0] seed, input bit gfc_on, input logic [3:0] gfc);
    for (int i = 0; i < 53; i++) q_mem[q_tail % 32][i] = cell_byte(h0, seed, i);
    if (gfc_on) q_mem[q_tail % 32][0] = {gfc, h0[3:0]};
    q_tail++;
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] b0, b1, b2, b3);
    logic [31:0] m;
    logic [7:0] c;
    m = {b0, b1, b2, b3};
    c = 8'h00;
    for (int k = 31; k >= 0; k--) begin
      logic fb;
      fb = c[7] ^ m[k];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  // output monitor
  logic [7:0] mb [0:52];
  int  mcnt = 0;
  bit  mhave = 0, midle = 0;

  task automatic check_cell();
    logic [7:0] plain, expb;
    int bad_hdr, bad_pay;
    logic [7:0] act_h, exp_h, act_p, exp_p;
    bit is_data;
    bad_hdr = 0; bad_pay = 0; act_h = 0; exp_h = 0; act_p = 0; exp_p = 0;
    is_data = !midle;
    chk(mb[4] == crc_ref(mb[0], mb[1], mb[2], mb[3]), "R9 check byte", mb[4], crc_ref(mb[0], mb[1], mb[2], mb[3]));
    if (midle) begin
      chk(mb[4] == 8'h52, "R9 idle check byte", mb[4], 8'h52);
    end else begin
      if (must_idle) chk(0, "R6 data cell during xoff", 1, 0);
      if (q_head == q_tail) begin
        chk(0, "R7 unexpected data cell", 1, 0);
        is_data = 0;
      end
    end
    for (int i = 0; i < 53; i++) begin
      if (i == 4) continue;
      if (is_data) plain = q_mem[q_head % 32][i];
      else if (i < 4) plain = (i == 3) ? 8'h01 : 8'h00;
      else plain = 8'h6A;
      expb = plain;
      if (i > 4 && tb_scr) begin
        for (int b = 7; b >= 0; b--) begin
          expb[b] = plain[b] ^ sst[42];
          sst = {sst[41:0], expb[b]};
        end
      end
      if (mb[i] != expb) begin
        if (i < 4) begin if (bad_hdr == 0) begin act_h = mb[i]; exp_h = expb; end bad_hdr++; end
        else begin if (bad_pay == 0) begin act_p = mb[i]; exp_p = expb; end bad_pay++; end
      end
    end
    if (is_data) begin q_head++; data_cells++; end
    chk(bad_hdr == 0, midle ? "R5 idle header" : (cfg_gfc_en ? "R8 header" : "R7 header"), act_h, exp_h);
    chk(bad_pay == 0, tb_scr ? "R10 payload" : (midle ? "R5 idle payload" : "R7 payload"), act_p, exp_p);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mcnt = 0; mhave = 0; sst = '0;
    end else begin
      if (tx_soc) begin
        if (mhave && mcnt != 53) chk(0, "R2 cell length", mcnt, 53);
        mcnt = 0; mhave = 1; midle = tx_idle;
        if (!tx_idle) saw_data = 1;
      end else if (mhave && mcnt == 53) begin
        chk(0, "R2 missing start flag", 0, 1);
        mhave = 0;
      end
      if (mhave && mcnt < 53) begin
        if (tx_idle != midle) chk(0, "R6 kind changed inside cell", tx_idle, midle);
        mb[mcnt] = tx_data;
        mcnt++;
        if (mcnt == 53) check_cell();
      end
    end
  end

  task automatic do_reset(input logic [2:0] d, input bit scr, input bit gfc, input bit xo);
    @(negedge clk);
    rst_n = 0; wr_en = 0; wr_soc = 0;
    cfg_depth = d; cfg_scr_en = scr; tb_scr = scr; cfg_gfc_en = gfc; xoff = xo;
    q_head = 0; q_tail = 0; data_cells = 0; saw_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
  endtask

  bit ovf1, ovf2;
  task automatic wr_cell(input logic [7:0] h0, input logic [7:0] seed, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      if (i == first + 1) ovf1 = wr_ovf;
      if (i == first + 2) ovf2 = wr_ovf;
      wr_en = 1; wr_soc = (i == 0); wr_data = cell_byte(h0, seed, i);
    end
    @(negedge clk);
    wr_en = 0; wr_soc = 0;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(tx_soc == 0, "R1 tx_soc in reset", tx_soc, 0);
    chk(tx_idle == 1, "R1 tx_idle in reset", tx_idle, 1);
    chk(wr_room == 1, "R1 wr_room in reset", wr_room, 1);
    chk(wr_ovf == 0, "R1 wr_ovf in reset", wr_ovf, 0);

    // R3/R4 sweep over every depth setting
    for (int d = 0; d < 8; d++) begin
      int deff;
      deff = (d == 0) ? 1 : ((d > 4) ? 4 : d);
      do_reset(3'(d), d[0], 0, 1);
      must_idle = 1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(wr_room == (k < deff), "R3 wr_room level", wr_room, (k < deff));
        wr_cell(8'h90 | 8'(k), 8'(16 * d + k), 0, 52);
        chk(ovf1 == (k >= deff), "R4 overflow flag", ovf1, (k >= deff));
        chk(ovf2 == 0, "R4 overflow single cycle", ovf2, 0);
        if (k < deff) push_cell(8'h90 | 8'(k), 8'(16 * d + k), 0, 4'h0);
      end
      repeat (60) @(negedge clk);
      chk(data_cells == 0, "R6 xoff holds data", data_cells, 0);
      must_idle = 0;
      xoff = 0;
      repeat (9 * 53) @(negedge clk);
      chk(data_cells == deff, "R3 R4 data cells sent", data_cells, deff);
      chk(q_head == q_tail, "R7 all cells drained", q_tail - q_head, 0);
      chk(wr_room == 1, "R3 room after drain", wr_room, 1);
    end

    // R8 late flow-control insertion, scrambler off
    do_reset(3'd4, 0, 1, 0);
    gfc_sdata = 1;
    repeat (8) @(negedge clk);
    push_cell(8'hA5, 8'h21, 1, 4'hF);
    wr_cell(8'hA5, 8'h21, 0, 52);
    repeat (130) @(negedge clk);
    chk(data_cells == 1, "R8 first cell out", data_cells, 1);
    gfc_sdata = 0;
    repeat (8) @(negedge clk);
    push_cell(8'hA5, 8'h37, 1, 4'h0);
    wr_cell(8'hA5, 8'h37, 0, 52);
    repeat (130) @(negedge clk);
    chk(data_cells == 2, "R8 second cell out", data_cells, 2);

    // R6 transmit-off raised inside a data cell
    do_reset(3'd4, 1, 0, 1);
    push_cell(8'h11, 8'h50, 0, 4'h0);
    wr_cell(8'h11, 8'h50, 0, 52);
    push_cell(8'h12, 8'h60, 0, 4'h0);
    wr_cell(8'h12, 8'h60, 0, 52);
    xoff = 0;
    for (int t = 0; t < 200 && !saw_data; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    xoff = 1;
    repeat (300) @(negedge clk);
    chk(data_cells == 1, "R6 started cell completes, next held", data_cells, 1);
    xoff = 0;
    repeat (200) @(negedge clk);
    chk(data_cells == 2, "R6 release after xoff", data_cells, 2);
    chk(q_head == q_tail, "R7 order and drain", q_tail - q_head, 0);

    // R5 partial cell is never sent
    do_reset(3'd4, 0, 0, 0);
    wr_cell(8'h77, 8'h05, 0, 29);
    repeat (200) @(negedge clk);
    chk(data_cells == 0, "R5 partial cell held", data_cells, 0);
    push_cell(8'h77, 8'h05, 0, 4'h0);
    wr_cell(8'h77, 8'h05, 30, 52);
    repeat (130) @(negedge clk);
    chk(data_cells == 1, "R5 completed cell sent", data_cells, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule